// File: doc/BRIEF.md
# SPI receive DMA engine

The engine pulls a block of bytes out of an SPI peripheral and stores it in system memory without any processor work per byte. Software loads a destination address and a byte length, then sets the go bit. For every byte the engine offers a filler value of 0xFF to an existing SPI byte shifter, waits for the byte shifted back, and issues one memory write at the next ascending address. When the length is used up it sets a sticky done flag. If enabled, it raises a single end-of-block interrupt.

While a block is in flight, the shifter's per-byte receive interrupt is masked from the processor. The whole block therefore costs one interrupt instead of one per byte, for example 512 for a storage sector. Memory back-pressure stalls the SPI side: the next filler byte is not offered until the previous write has been acknowledged, so no received byte is ever dropped.

The sequencer has five states. ST_IDLE waits for go. ST_FILL offers the filler byte until the shifter accepts it. ST_LISTEN waits for the returned byte and captures it. ST_STORE holds the memory write request until it is acknowledged. ST_WRAP is a single cycle that sets the done flag. The transitions are:

- ST_IDLE to ST_FILL on go with a non-zero length.
- ST_IDLE to ST_WRAP on go with a zero length.
- ST_FILL to ST_LISTEN on filler accepted.
- ST_LISTEN to ST_STORE on byte returned.
- ST_STORE to ST_FILL on an acknowledge with bytes remaining.
- ST_STORE to ST_WRAP on the acknowledge of the last byte.
- ST_WRAP to ST_IDLE unconditionally.

Top module: `spi_rx_dma`

## Requirements
- R1: After go with length N, exactly N filler bytes of value 0xFF are offered on the SPI transmit handshake, each one before the byte it brings back is captured.
- R2: The byte returned for the i-th filler (counting from 0) is written to memory at destination + i, in ascending order, with the captured value on the write data.
- R3: At most one byte is in flight. A filler is not offered while a returned byte awaits capture or its memory write awaits acknowledge. A pending request (filler or write) holds its address and data until accepted.
- R4: Go with length 0 causes no SPI filler and no memory write. Done reads as set on the second clock edge after the go write.
- R5: Done, and the interrupt when enabled, stay set until software writes 1 to status bit 1 or issues a new go, which clears done.
- R6: A go write while busy is ignored. The running block keeps its original destination and length, even if the destination and length registers are rewritten meanwhile.
- R7: The SPI per-byte interrupt input reaches the processor interrupt output only while the engine is not busy.
- R8: The register map is selected by a 2-bit index. Index 0 is destination, index 1 is length, and index 2 is control (bit 0 go, which is write-only and reads as 0; bit 1 interrupt enable). Index 3 is status (bit 0 busy, bit 1 done).
- R9: After reset, all registers read 0, the interrupt is low, and no SPI or memory request is active.
- R10: The interrupt output equals done while interrupt enable is 1 and stays low while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| irq | output | 1 | End-of-block interrupt |
| spi_tx_valid | output | 1 | Filler byte offered to the shifter |
| spi_tx_data | output | 8 | Filler byte value |
| spi_tx_ready | input | 1 | Shifter accepts the filler |
| spi_rx_valid | input | 1 | Returned byte strobe |
| spi_rx_data | input | 8 | Returned byte |
| spi_byte_irq | input | 1 | Per-byte interrupt from the shifter |
| cpu_spi_irq | output | 1 | Per-byte interrupt toward the processor, masked while busy |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |

## Verification
The assertions watch properties that hold on every cycle:

- Pending filler and write requests are held stable until accepted.
- Filler and write requests are never active together.
- The write address advances by one after each acknowledge.
- The done flag is sticky.
- A go while busy never reloads the address.
- The per-byte interrupt is masked while busy.

Only the bench scenarios can show the end-to-end properties:

- Exact filler count per block, and memory contents against the responder's byte sequence.
- A single interrupt rise per block.
- Zero-length completion timing.
- Done clearing by write-1 and by a new go.

// File: rtl/spi_rx_dma_pkg.sv
package spi_rx_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_LISTEN,
        ST_STORE,
        ST_WRAP
    } seq_state_t;

    localparam logic [1:0] SEL_DST  = 2'd0;
    localparam logic [1:0] SEL_LEN  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int CTRL_GO   = 0;
    localparam int CTRL_IE   = 1;
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
endpackage

// File: rtl/spi_rx_dma_regs.sv
module spi_rx_dma_regs
    import spi_rx_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          finish,
    output logic          go,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] len_q,
    output logic          irq
);
    logic ie_q;
    logic done_q;
    logic clr_wr;

    // go is only honoured while the sequencer is idle (R6)
    assign go     = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_GO] && !busy;
    assign clr_wr = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[STAT_DONE];
    assign irq    = done_q && ie_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q  <= '0;
            len_q  <= '0;
            ie_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_DST)  dst_q <= reg_wdata[AW-1:0];
            if (reg_wr && reg_sel == SEL_LEN)  len_q <= reg_wdata[CW-1:0];
            if (reg_wr && reg_sel == SEL_CTRL) ie_q  <= reg_wdata[CTRL_IE];
            if (finish)
                done_q <= 1'b1;
            else if (go || clr_wr)
                done_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_DST:  reg_rdata[AW-1:0] = dst_q;
            SEL_LEN:  reg_rdata[CW-1:0] = len_q;
            SEL_CTRL: reg_rdata[CTRL_IE] = ie_q;
            SEL_STAT: begin
                reg_rdata[STAT_BUSY] = busy;
                reg_rdata[STAT_DONE] = done_q;
            end
        endcase
    end

    // R5: done is sticky until a clear write or a new go
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_wr && !go) |=> done_q);

    // R5: completion always leaves done set
    a_r5_finish_sets: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q);
endmodule

// File: rtl/spi_rx_dma_ptr.sv
module spi_rx_dma_ptr #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] len,
    output logic [AW-1:0] cur_addr,
    output logic          last,
    output logic          empty
);
    logic [CW-1:0] remain_q;

    assign empty = (len == '0);
    assign last  = (remain_q == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain_q <= '0;
        end else if (load) begin
            cur_addr <= base;
            remain_q <= len;
        end else if (step) begin
            cur_addr <= cur_addr + AW'(1);
            remain_q <= remain_q - CW'(1);
        end
    end

    // R1: a byte is never stored with nothing left to transfer
    a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain_q != '0));
endmodule

// File: rtl/spi_rx_dma_seq.sv
module spi_rx_dma_seq
    import spi_rx_dma_pkg::*;
#(
    parameter logic [7:0] FILL = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       zero_len,
    input  logic       last,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       mem_ack,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       mem_req,
    output logic [7:0] byte_q,
    output logic       step,
    output logic       finish,
    output logic       busy
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)    nxt = zero_len ? ST_WRAP : ST_FILL;
            ST_FILL:   if (tx_ready) nxt = ST_LISTEN;
            ST_LISTEN: if (rx_valid) nxt = ST_STORE;
            ST_STORE:  if (mem_ack)  nxt = last ? ST_WRAP : ST_FILL;
            ST_WRAP:                 nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = 1'b0;
        mem_req  = 1'b0;
        step     = 1'b0;
        finish   = 1'b0;
        busy     = 1'b1;
        tx_data  = FILL;
        unique case (state)
            ST_IDLE:   busy     = 1'b0;
            ST_FILL:   tx_valid = 1'b1;
            ST_LISTEN: ;
            ST_STORE: begin
                mem_req = 1'b1;
                step    = mem_ack;
            end
            ST_WRAP:   finish   = 1'b1;
            default:   busy     = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             byte_q <= '0;
        else if (state == ST_LISTEN && rx_valid) byte_q <= rx_data;
    end

    // R3: an offered filler stays offered until accepted
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    // R3: a write request holds its data until acknowledged
    a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(byte_q)));

    // R3: SPI side and memory side never active together
    a_r3_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && mem_req));

    // R4: zero length produces no traffic on the next cycle
    a_r4_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && zero_len) |=> (!tx_valid && !mem_req && finish));
endmodule

// File: rtl/spi_rx_dma.sv
module spi_rx_dma
    import spi_rx_dma_pkg::*;
#(
    parameter int         AW   = 32,
    parameter int         CW   = 16,
    parameter int         RW   = 32,
    parameter logic [7:0] FILL = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          irq,
    output logic          spi_tx_valid,
    output logic [7:0]    spi_tx_data,
    input  logic          spi_tx_ready,
    input  logic          spi_rx_valid,
    input  logic [7:0]    spi_rx_data,
    input  logic          spi_byte_irq,
    output logic          cpu_spi_irq,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    input  logic          mem_ack
);
    logic          go, busy, finish, step, last, empty;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] len_q;

    spi_rx_dma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .finish(finish), .go(go), .dst_q(dst_q), .len_q(len_q), .irq(irq)
    );

    spi_rx_dma_ptr #(.AW(AW), .CW(CW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(go), .step(step), .base(dst_q),
        .len(len_q), .cur_addr(mem_addr), .last(last), .empty(empty)
    );

    spi_rx_dma_seq #(.FILL(FILL)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(go), .zero_len(empty), .last(last),
        .tx_ready(spi_tx_ready), .rx_valid(spi_rx_valid), .rx_data(spi_rx_data),
        .mem_ack(mem_ack), .tx_valid(spi_tx_valid), .tx_data(spi_tx_data),
        .mem_req(mem_req), .byte_q(mem_data), .step(step), .finish(finish),
        .busy(busy)
    );

    // per-byte interrupt is hidden from the processor during a block (R7)
    assign cpu_spi_irq = spi_byte_irq && !busy;

    // R7: no per-byte interrupt escapes while busy
    a_r7_mask_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_spi_irq);

    // R2: address advances by one after each acknowledged write
    a_r2_addr_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + AW'(1)));

    // R6: a go write while busy does not reload the address
    a_r6_busy_start_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_sel == SEL_CTRL && reg_wdata[CTRL_GO])
        |=> (mem_addr == $past(mem_addr) || $past(mem_ack)));
endmodule

// File: tb/sim_spi_rx_dma.sv
`timescale 1ns/1ps
module sim_spi_rx_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, spi_tx_valid, cpu_spi_irq, mem_req;
    logic [7:0]  spi_tx_data, mem_data;
    logic [31:0] mem_addr;
    logic        spi_tx_ready = 1'b0, spi_rx_valid = 1'b0, spi_byte_irq = 1'b0, mem_ack = 1'b0;
    logic [7:0]  spi_rx_data = '0;

    always #2.5 clk = ~clk;

    spi_rx_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .spi_tx_valid(spi_tx_valid), .spi_tx_data(spi_tx_data),
        .spi_tx_ready(spi_tx_ready), .spi_rx_valid(spi_rx_valid),
        .spi_rx_data(spi_rx_data), .spi_byte_irq(spi_byte_irq),
        .cpu_spi_irq(cpu_spi_irq), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ack(mem_ack)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model state
    bit          mbusy = 0, mdone = 0, mie = 0, fin_stage = 0;
    int          idx = 0, mcount = 0;
    logic [31:0] mdst = 0, rdst = 0;
    int          rlen = 0;
    int          tx_out = 0, tx_total = 0, wr_total = 0, irq_rises = 0;
    bit          irq_prev = 0, hs_flag = 0;
    byte         rxq[$];
    byte         hist[$];
    logic [7:0]  mem[int];

    always @(posedge clk) begin
        if (rst_n) begin
            bit busy_pre;
            busy_pre = mbusy;
            // compare pre-edge outputs against model
            chk(irq == (mdone && mie), "R10", "irq", irq, mdone && mie);
            chk(cpu_spi_irq == (spi_byte_irq && !mbusy), "R7", "cpu_spi_irq",
                cpu_spi_irq, spi_byte_irq && !mbusy);
            if (spi_tx_valid) begin
                chk(mbusy && tx_out == 0, "R3", "filler while byte in flight", tx_out, 0);
                chk(spi_tx_data == 8'hFF, "R1", "filler value", spi_tx_data, 8'hFF);
            end
            if (!mbusy) chk(!spi_tx_valid && !mem_req, "R4", "traffic while idle",
                            {spi_tx_valid, mem_req}, 0);
            if (mem_req) begin
                chk(mem_addr == mdst + idx, "R2", "write address", mem_addr, mdst + idx);
                if (mem_ack) begin
                    chk(rxq.size() > 0 && mem_data == rxq[0], "R2", "write data",
                        mem_data, rxq.size() > 0 ? rxq[0] : 0);
                end
            end
            if (irq && !irq_prev) irq_rises++;
            irq_prev = irq;
            // model update
            if (fin_stage) begin
                fin_stage = 0;
                mdone = 1;
                mbusy = 0;
            end
            if (spi_tx_valid && spi_tx_ready) begin
                tx_out++;
                tx_total++;
                hs_flag = 1;
            end
            if (mem_req && mem_ack) begin
                mem[mem_addr] = mem_data;
                if (rxq.size() > 0) void'(rxq.pop_front());
                idx++;
                tx_out--;
                wr_total++;
                if (idx == mcount) fin_stage = 1;
            end
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: rdst = reg_wdata;
                    2'd1: rlen = int'(reg_wdata[15:0]);
                    2'd2: begin
                        mie = reg_wdata[1];
                        if (reg_wdata[0] && !busy_pre) begin
                            mbusy = 1;
                            mdone = 0;
                            idx = 0;
                            mcount = rlen;
                            mdst = rdst;
                            if (rlen == 0) fin_stage = 1;
                        end
                    end
                    default: if (reg_wdata[1] && !fin_stage) mdone = 0;
                endcase
            end
        end
    end

    // behavioural SPI responder and memory with random acknowledge delay
    initial begin
        int pend;
        byte pat;
        pend = 0;
        pat = 8'h3C;
        forever begin
            @(negedge clk);
            spi_rx_valid = 1'b0;
            if (hs_flag) begin
                hs_flag = 0;
                pend = 1 + int'($urandom % 4);
            end
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    spi_rx_valid = 1'b1;
                    spi_rx_data = pat;
                    rxq.push_back(pat);
                    hist.push_back(pat);
                    pat = pat * 8'd13 + 8'd7;
                end
            end
            spi_tx_ready = ($urandom % 2) == 0;
            mem_ack = mem_req && (($urandom % 3) == 0);
            spi_byte_irq = ($urandom % 2) == 0;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_sel = 2'd0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_sel = sel;
        #1;
        chk(reg_rdata == exp, req, "register read", reg_rdata, exp);
        reg_sel = 2'd0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 30000 && mbusy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_block(input logic [31:0] dst, input int len, input bit ie,
                             input string req);
        int t0, w0, r0, h0;
        t0 = tx_total; w0 = wr_total; r0 = irq_rises; h0 = hist.size();
        wr(2'd0, dst);
        wr(2'd1, len);
        wr(2'd2, {30'd0, ie, 1'b1});
        rd(2'd3, 32'h1, "R8");
        wait_idle();
        chk(tx_total - t0 == len, "R1", "filler count", tx_total - t0, len);
        chk(wr_total - w0 == len, "R2", "write count", wr_total - w0, len);
        for (int i = 0; i < len; i++) begin
            if (!mem.exists(dst + i) || mem[dst + i] != hist[h0 + i]) begin
                chk(0, "R2", "memory byte", mem.exists(dst + i) ? mem[dst + i] : 0,
                    hist[h0 + i]);
            end
        end
        chk(1, "R2", "memory block", 0, 0);
        chk(irq_rises - r0 == (ie ? 1 : 0), req, "interrupt rises", irq_rises - r0, ie);
        rd(2'd3, 32'h2, "R5");
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t0, w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        rd(2'd0, 0, "R9");
        rd(2'd1, 0, "R9");
        rd(2'd2, 0, "R9");
        rd(2'd3, 0, "R9");
        chk(!irq && !spi_tx_valid && !mem_req, "R9", "outputs idle",
            {irq, spi_tx_valid, mem_req}, 0);

        // R1 R2: short block with interrupt enabled
        run_block(32'h100, 16, 1'b1, "R10");
        rd(2'd2, 32'h2, "R8");
        // R5: sticky done and interrupt
        repeat (20) @(negedge clk);
        chk(irq == 1'b1, "R5", "irq held", irq, 1);
        wr(2'd3, 32'h2);
        rd(2'd3, 32'h0, "R5");
        chk(irq == 1'b0, "R5", "irq cleared", irq, 0);

        // R4: zero length
        t0 = tx_total; w0 = wr_total;
        wr(2'd1, 0);
        wr(2'd2, 32'h3);
        rd(2'd3, 32'h2, "R4");
        chk(tx_total == t0 && wr_total == w0, "R4", "no traffic",
            tx_total - t0 + wr_total - w0, 0);
        wr(2'd3, 32'h2);

        // R6: start while busy ignored, registers rewritten mid-block
        t0 = tx_total; w0 = hist.size();
        wr(2'd0, 32'h2000);
        wr(2'd1, 512);
        wr(2'd2, 32'h1);
        repeat (100) @(negedge clk);
        wr(2'd0, 32'h9000);
        wr(2'd1, 5);
        wr(2'd2, 32'h1);
        rd(2'd3, 32'h1, "R6");
        wait_idle();
        chk(tx_total - t0 == 512, "R6", "block length kept", tx_total - t0, 512);
        chk(!mem.exists(32'h9000), "R6", "no write at new base", 0, 0);
        for (int i = 0; i < 512; i++)
            if (!mem.exists(32'h2000 + i) || mem[32'h2000 + i] != hist[w0 + i])
                chk(0, "R6", "block byte", i, i);
        // R10: done set but interrupt disabled
        rd(2'd3, 32'h2, "R10");
        chk(irq == 1'b0, "R10", "irq with ie=0", irq, 0);
        // R5: new go clears done
        wr(2'd2, 32'h1);
        rd(2'd3, 32'h1, "R5");
        wait_idle();
        chk(mem.exists(32'h9004) && !mem.exists(32'h9005), "R2", "five bytes at new base",
            mem.exists(32'h9005), 0);

        // back-pressure heavy block
        run_block(32'h4000, 64, 1'b1, "R3");
        wr(2'd3, 32'h2);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule